// File: doc/BRIEF.md
# Region-Based Bus Wait-State Generator

This block stalls a processor bus for as many clock cycles as the addressed memory region needs. The upper four address bits pick one of sixteen regions. Each region has two 16-bit access costs: one for a non-sequential access and one for a sequential access. A 32-bit access is charged as two back-to-back halves. A single packed control word, written by software, sets the costs of the three cartridge ROM windows and of the save RAM. The external work RAM has a fixed cost, and every other region is free.

An access starts with a one-cycle request strobe. The strobe carries the address, a width flag and a sequential flag. The block looks up the cost, loads a down-counter, and holds `ready` low until the stall is used up. The remaining count is visible on `wait_cnt`. A prefetch-enable bit in the same control word is passed out for the fetch logic. The memories, the prefetch buffer and the data path are outside this block.

Top module: `waitstate_gen`

## Requirements
- R1: The region index is the top four address bits (addr[27:24] at the default width). The lower address bits have no effect on the cost.
- R2: After reset, region 2 costs 2 cycles for 16-bit accesses, both non-sequential and sequential. ROM regions 8..13 and save region 14 cost 4 non-sequential. Their sequential costs are 2,2,4,4,8,8 for regions 8..13 and 4 for region 14. Region 2 keeps its cost of 2 under every control value.
- R3: Regions 0, 1, 3..7 and 15 have a 16-bit cost of 0 and a 32-bit cost of 1.
- R4: A 2-bit non-sequential code maps 0→4, 1→3, 2→2, 3→8. It sits at cfg[3:2] for window 0 (regions 8/9), cfg[6:5] for window 1 (regions 10/11) and cfg[9:8] for window 2 (regions 12/13).
- R5: A sequential select bit of 1 gives a cost of 1. A bit of 0 gives 2 for window 0 (cfg[4]), 4 for window 1 (cfg[7]) and 8 for window 2 (cfg[10]).
- R6: The two regions of each ROM window always have identical costs.
- R7: Save region 14 takes its code from cfg[1:0], using the R4 map, for both sequential and non-sequential 16-bit accesses.
- R8: With wide=1, a non-sequential access costs N+S+1 and a sequential access costs 2S+1. Here N and S are the region's 16-bit non-sequential and sequential costs. With wide=0 (8 or 16 bit), the cost is N or S.
- R9: For a request of cost C>0, `ready` is low in the request cycle and the next C-1 cycles. In that time `wait_cnt` shows C-1 down to 1, one cycle after the request, and `ready` is high at count 0. A request of cost 0 sees `ready` high in its own cycle.
- R10: A request raised while `wait_cnt` is nonzero is ignored. It neither extends nor restarts the stall.
- R11: A control write applies to requests from the cycle after the write. A request in the same cycle as the write, and an access already stalling, keep the old costs.
- R12: `prefetch_en` equals bit 14 of the last control write and is 0 after reset.
- R13: After reset, `ready` is 1 and `wait_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word value |
| req | input | 1 | Access request strobe, one cycle |
| addr | input | ADDR_W | Access address; top four bits select the region |
| wide | input | 1 | 1 = 32-bit access, 0 = 8/16-bit |
| seq | input | 1 | 1 = sequential access |
| ready | output | 1 | High when the bus is not stalled |
| wait_cnt | output | 5 | Stall cycles still to run |
| prefetch_en | output | 1 | Prefetch enable from the control word |

## Verification
The stall decision is combinational on the request. The bench therefore reads `ready` just after driving the strobe, in the request cycle itself. It reads `wait_cnt` one clock edge later, where it must show C-1. It then counts the low cycles of `ready` until the first high one, so the measured cost is C cycles from the request. A control write appears on `prefetch_en` one edge after the strobe and is read at the following falling edge. For writes in the request cycle and in a stall cycle, the expected costs use the old control word for that access and the new word for the next one.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

  localparam int REGION_BITS   = 4;
  localparam int NUM_REGIONS   = 1 << REGION_BITS;
  localparam int NUM_WINDOWS   = 3;
  localparam int WAIT_W        = 4;
  localparam int MAX_HALF_WAIT = 8;
  localparam int MAX_COST      = 2 * MAX_HALF_WAIT + 1;
  localparam int COST_W        = $clog2(MAX_COST + 1);
  localparam int CFG_W         = 16;

  localparam int RG_EXT_RAM    = 2;
  localparam int RG_ROM_FIRST  = 8;
  localparam int RG_SAVE       = 14;
  localparam int EXT_RAM_WAIT  = 2;

  typedef logic [WAIT_W-1:0] wait_t;

  typedef struct packed {
    logic [1:0] ns_code;
    logic       sq_sel;
  } window_cfg_t;

  typedef struct packed {
    window_cfg_t [NUM_WINDOWS-1:0] win;
    logic [1:0]                    save_code;
    logic                          prefetch;
  } wait_cfg_t;

  typedef struct packed {
    wait_t ns;
    wait_t sq;
  } region_wait_t;

  // Non-sequential code to cycle count
  function automatic wait_t ns_code_wait(input logic [1:0] code);
    case (code)
      2'd0:    return wait_t'(4);
      2'd1:    return wait_t'(3);
      2'd2:    return wait_t'(2);
      default: return wait_t'(8);
    endcase
  endfunction

  // Sequential select: 1 -> one cycle, 0 -> 2, 4 or 8 by window
  function automatic wait_t seq_sel_wait(input logic [1:0] win, input logic sel);
    if (sel) return wait_t'(1);
    return wait_t'(2 << win);
  endfunction

  function automatic region_wait_t region_entry(input int idx, input wait_cfg_t cfg);
    region_wait_t e;
    logic [1:0]   w;
    e.ns = '0;
    e.sq = '0;
    w    = 2'((idx - RG_ROM_FIRST) >> 1);
    if (idx == RG_EXT_RAM) begin
      e.ns = wait_t'(EXT_RAM_WAIT);
      e.sq = wait_t'(EXT_RAM_WAIT);
    end else if (idx >= RG_ROM_FIRST && idx < RG_SAVE) begin
      e.ns = ns_code_wait(cfg.win[w].ns_code);
      e.sq = seq_sel_wait(w, cfg.win[w].sq_sel);
    end else if (idx == RG_SAVE) begin
      e.ns = ns_code_wait(cfg.save_code);
      e.sq = ns_code_wait(cfg.save_code);
    end
    return e;
  endfunction

endpackage

// File: rtl/wsg_rst_sync.sv
module wsg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/wsg_ctrl_reg.sv
module wsg_ctrl_reg
  import wsg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output wait_cfg_t        cfg
);

  wait_cfg_t cfg_q, cfg_d, wr_fields;
  logic      unused_wr_bits;

  // Field unpacking of the software control word
  always_comb begin
    wr_fields.save_code      = wr_data[1:0];
    wr_fields.win[0].ns_code = wr_data[3:2];
    wr_fields.win[0].sq_sel  = wr_data[4];
    wr_fields.win[1].ns_code = wr_data[6:5];
    wr_fields.win[1].sq_sel  = wr_data[7];
    wr_fields.win[2].ns_code = wr_data[9:8];
    wr_fields.win[2].sq_sel  = wr_data[10];
    wr_fields.prefetch       = wr_data[14];
  end

  assign unused_wr_bits = ^{wr_data[15], wr_data[13:11]};

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wr_fields;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/wsg_region_table.sv
module wsg_region_table
  import wsg_pkg::*;
(
  input  wait_cfg_t              cfg,
  input  logic [REGION_BITS-1:0] region,
  output region_wait_t           sel
);

  region_wait_t entries [NUM_REGIONS];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    assign entries[g] = region_entry(g, cfg);
  end

  assign sel = entries[region];

endmodule

// File: rtl/wsg_cost_calc.sv
module wsg_cost_calc
  import wsg_pkg::*;
(
  input  region_wait_t      rw,
  input  logic              wide,
  input  logic              seq,
  output logic [COST_W-1:0] cost
);

  logic [COST_W-1:0] ns_x, sq_x, first_half;

  always_comb begin
    ns_x       = COST_W'(rw.ns);
    sq_x       = COST_W'(rw.sq);
    first_half = seq ? sq_x : ns_x;
    if (wide) cost = first_half + sq_x + COST_W'(1);
    else      cost = first_half;
  end

endmodule

// File: rtl/wsg_stall_ctr.sv
module wsg_stall_ctr #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [CNT_W-1:0] cost,
  output logic             ready,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             idle, load, cnt_en;

  always_comb begin
    idle   = (cnt_q == '0);
    load   = req && idle && (cost != '0);
    cnt_en = load || !idle;
    cnt_d  = cnt_q;
    if (load)       cnt_d = cost - CNT_W'(1);
    else if (!idle) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready = idle && !load;
  assign cnt   = cnt_q;

endmodule

// File: rtl/waitstate_gen.sv
module waitstate_gen
  import wsg_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  input  logic              seq,
  output logic              ready,
  output logic [COST_W-1:0] wait_cnt,
  output logic              prefetch_en
);

  localparam int OFFSET_W = ADDR_W - REGION_BITS;

  logic                   rst_n_sync;
  wait_cfg_t              cfg;
  logic [REGION_BITS-1:0] region;
  region_wait_t           rw;
  logic [COST_W-1:0]      cost;
  logic                   unused_offset;

  assign region        = addr[ADDR_W-1 -: REGION_BITS];
  assign unused_offset = ^addr[OFFSET_W-1:0];

  wsg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  wsg_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .cfg     (cfg)
  );

  wsg_region_table u_table (
    .cfg    (cfg),
    .region (region),
    .sel    (rw)
  );

  wsg_cost_calc u_cost (
    .rw   (rw),
    .wide (wide),
    .seq  (seq),
    .cost (cost)
  );

  wsg_stall_ctr #(.CNT_W(COST_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .req   (req),
    .cost  (cost),
    .ready (ready),
    .cnt   (wait_cnt)
  );

  assign prefetch_en = cfg.prefetch;

endmodule

// File: rtl/waitstate_gen_chk.sv
module waitstate_gen_chk
  import wsg_pkg::*;
#(
  parameter int ADDR_W = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [CFG_W-1:0]  cfg_wdata,
  input logic              req,
  input logic [ADDR_W-1:0] addr,
  input logic              wide,
  input logic              ready,
  input logic [COST_W-1:0] wait_cnt,
  input logic              prefetch_en
);

  logic [REGION_BITS-1:0] rg;
  assign rg = addr[ADDR_W-1 -: REGION_BITS];

  p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_cnt != '0) |-> !ready);

  p_count_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_cnt != '0) |=> (wait_cnt == $past(wait_cnt) - COST_W'(1)));

  p_busy_req_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_cnt != '0 && req) |=> (wait_cnt == $past(wait_cnt) - COST_W'(1)));

  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_cnt == '0 && !req) |=> (wait_cnt == '0));

  p_zero_cost_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready) |=> (wait_cnt == '0));

  p_cost_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= COST_W'(MAX_COST - 1));

  p_ext_ram_cost_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && wait_cnt == '0 && rg == REGION_BITS'(RG_EXT_RAM) && !wide)
      |-> (!ready ##1 (wait_cnt == COST_W'(1))));

  p_free_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && wait_cnt == '0 && rg == REGION_BITS'(3) && !wide) |-> ready);

  p_prefetch_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (prefetch_en == $past(cfg_wdata[14])));

  p_prefetch_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(prefetch_en));

endmodule

bind waitstate_gen waitstate_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .cfg_we      (cfg_we),
  .cfg_wdata   (cfg_wdata),
  .req         (req),
  .addr        (addr),
  .wide        (wide),
  .ready       (ready),
  .wait_cnt    (wait_cnt),
  .prefetch_en (prefetch_en)
);

// File: tb/waitstate_gen_bench.sv
module waitstate_gen_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int ADDR_W = 28;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we;
  logic [15:0]       cfg_wdata;
  logic              req;
  logic [ADDR_W-1:0] addr;
  logic              wide;
  logic              seq;
  logic              ready;
  logic [4:0]        wait_cnt;
  logic              prefetch_en;

  int          checks = 0;
  int          errors = 0;
  logic [15:0] model_cfg;

  always #2 clk = ~clk;

  waitstate_gen #(.ADDR_W(ADDR_W)) u_waitstate_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req(req), .addr(addr), .wide(wide), .seq(seq),
    .ready(ready), .wait_cnt(wait_cnt), .prefetch_en(prefetch_en)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int nsmap(input logic [1:0] c);
    case (c)
      2'd0: return 4;
      2'd1: return 3;
      2'd2: return 2;
      default: return 8;
    endcase
  endfunction

  function automatic int exp_cost(input logic [15:0] c, input int rg, input bit w, input bit s);
    int n = 0, q = 0;
    if (rg == 2) begin n = 2; q = 2; end
    else if (rg == 8 || rg == 9)   begin n = nsmap(c[3:2]); q = c[4]  ? 1 : 2; end
    else if (rg == 10 || rg == 11) begin n = nsmap(c[6:5]); q = c[7]  ? 1 : 4; end
    else if (rg == 12 || rg == 13) begin n = nsmap(c[9:8]); q = c[10] ? 1 : 8; end
    else if (rg == 14) begin n = nsmap(c[1:0]); q = n; end
    if (w) return s ? (2 * q + 1) : (n + q + 1);
    return s ? q : n;
  endfunction

  function automatic string tag_for(input int rg, input bit w, input bit s);
    if (w) return "R1 R8";
    if (rg == 2) return "R1 R2";
    if (rg == 14) return "R1 R7";
    if (rg >= 8 && rg <= 13) return s ? "R1 R5 R6" : "R1 R4 R6";
    return "R1 R3";
  endfunction

  // wr_at: 0 none, 1 in the request cycle, 2 in the first cycle after it
  task automatic do_access(input int rg, input bit w, input bit s, input int wr_at,
                           input logic [15:0] wv, output int cost, output int cnt1);
    @(negedge clk);
    addr = {4'(rg), (ADDR_W-4)'($urandom)};
    wide = w; seq = s; req = 1'b1;
    if (wr_at == 1) begin cfg_we = 1'b1; cfg_wdata = wv; end
    #1;
    cost = ready ? 0 : 1;
    @(negedge clk);
    req = 1'b0; cfg_we = 1'b0;
    if (wr_at == 2) begin cfg_we = 1'b1; cfg_wdata = wv; end
    #1;
    cnt1 = int'(wait_cnt);
    while (!ready) begin
      cost++;
      @(negedge clk);
      cfg_we = 1'b0;
      #1;
    end
    if (cfg_we) begin @(negedge clk); cfg_we = 1'b0; end
  endtask

  task automatic run_check(input int rg, input bit w, input bit s, input string tag);
    int c, c1, e;
    e = exp_cost(model_cfg, rg, w, s);
    do_access(rg, w, s, 0, 16'h0, c, c1);
    chk(c == e, {tag, " cost"}, c, e);
    chk(c1 == (e > 0 ? e - 1 : 0), "R9 count after request", c1, (e > 0 ? e - 1 : 0));
  endtask

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    model_cfg = v;
    #1;
    chk(prefetch_en == v[14], "R12 prefetch", int'(prefetch_en), int'(v[14]));
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c, c1;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; req = 1'b0;
    addr = '0; wide = 1'b0; seq = 1'b0; model_cfg = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R13 reset state, R12 prefetch cleared
    chk(ready == 1'b1, "R13 ready", int'(ready), 1);
    chk(wait_cnt == 5'd0, "R13 wait_cnt", int'(wait_cnt), 0);
    chk(prefetch_en == 1'b0, "R12 reset prefetch", int'(prefetch_en), 0);

    // R2 reset costs over every region and mode
    for (int rg = 0; rg < 16; rg++)
      for (int m = 0; m < 4; m++)
        run_check(rg, m[1], m[0], (m[1] ? "R2 R8" : "R2"));

    // Sweep of control codes: every ns code per window, every seq select pattern
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b < 8; b++) begin
        logic [15:0] v;
        v = 16'(((b & 1) << 14) | (((b >> 2) & 1) << 10) | (((k + 2) % 4) << 8) |
                (((b >> 1) & 1) << 7) | (((k + 1) % 4) << 5) | ((b & 1) << 4) |
                (k << 2) | ((k + 3) % 4));
        write_cfg(v);
        for (int rg = 0; rg < 16; rg++)
          for (int m = 0; m < 4; m++)
            run_check(rg, m[1], m[0], tag_for(rg, m[1], m[0]));
      end
    end

    // R10: request during a stall is ignored
    write_cfg(16'h0000);
    @(negedge clk);
    addr = {4'd8, (ADDR_W-4)'($urandom)}; wide = 1'b0; seq = 1'b0; req = 1'b1;
    #1;
    c = ready ? 0 : 1;
    @(negedge clk);
    addr = {4'd14, (ADDR_W-4)'($urandom)}; wide = 1'b1; req = 1'b1;
    #1;
    chk(wait_cnt == 5'd3, "R10 count with busy request", int'(wait_cnt), 3);
    if (!ready) c++;
    @(negedge clk);
    req = 1'b0;
    #1;
    while (!ready) begin c++; @(negedge clk); #1; end
    chk(c == 4, "R10 stall length", c, 4);
    @(negedge clk);
    #1;
    chk(wait_cnt == 5'd0 && ready, "R10 no restart", int'(wait_cnt), 0);

    // R11: write in the request cycle keeps the old cost
    do_access(8, 1'b0, 1'b0, 1, 16'h000C, c, c1);
    chk(c == 4, "R11 same-cycle write uses old", c, 4);
    model_cfg = 16'h000C;
    run_check(8, 1'b0, 1'b0, "R11 new cost next access");
    // R11: write during a stall leaves the running access alone
    do_access(9, 1'b0, 1'b0, 2, 16'h0008, c, c1);
    chk(c == 8, "R11 in-flight access unchanged", c, 8);
    model_cfg = 16'h0008;
    run_check(9, 1'b0, 1'b0, "R11 after mid-stall write");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule